// File: doc/BRIEF.md
# H-Bridge Gate Pattern Sequencer

This block turns one pulse-width drive line into the four gate enables of a full bridge: left-top, left-bottom, right-top and right-bottom. Each rising edge of the drive starts a new drive period. During the high phase one diagonal pair conducts, and the pair used swaps from one period to the next. During the low phase a 2-bit freewheel mode decides whether the load floats, is shorted through the bottom switches, or is shorted through a rail that swaps between the top pair and the bottom pair on successive low phases. Spreading the short across both rails shares the conduction heating among all four devices.

Each leg has its own dead-time stage. A switch that is no longer requested is released at once. The opposite switch of the same leg turns on only after the leg has been fully off for a programmable number of clock cycles. A fault input latches and blanks all four gates until the next synchronous reset.

Top module: `hbridge_seq`

## Requirements
- R1: While `rst` is high at a clock edge, all four gates are off after that edge. Reset sets the period parity to even and sets the alternation rail to bottom. After reset no gate turns on until the drive line has changed.
- R2: The first drive period after reset is even. Even periods request left-top and right-bottom during the high phase, with left-bottom and right-top off.
- R3: Every rising edge of `drive_i` toggles the parity. Odd periods request right-top and left-bottom during the high phase, with the other two off.
- R4: With `mode_i` = 0 (float), or the spare code 3, all four gates are requested off during the low phase.
- R5: With `mode_i` = 1 (bottom short), the low phase requests left-bottom and right-bottom on and both top switches off.
- R6: With `mode_i` = 2 (alternating short), the first such low phase after reset shorts through the bottom pair and the next one through the top pair, and so on. Low phases in any other mode do not advance this rail.
- R7: The top and bottom gate of one leg are never on together.
- R8: A drive edge that `drive_i` presents before clock edge k changes the requested pattern at edge k. At edge k+1 each leg drops any switch that is no longer requested. A switch turns on only once its leg has been fully off for at least max(D,1) cycles, where D is `dead_i`. A leg that has been idle that long, or since reset, turns on at edge k+1.
- R9: `mode_i` is sampled only at the clock edge where the drive low phase is first seen. Changes later in that low phase have no effect on the gates.
- R10: When `fault_i` is high at a clock edge, all gates are off after that edge. They stay off, whatever the drive, mode or fault inputs do, until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_i | input | 1 | Pulse-width drive line; a rising edge starts a period |
| mode_i | input | 2 | Freewheel mode: 0 float, 1 bottom short, 2 alternating short, 3 float |
| dead_i | input | DEAD_W | Dead time in clock cycles |
| fault_i | input | 1 | Fault; latches and blanks all gates until reset |
| gate_lt_o | output | 1 | Left-top gate enable |
| gate_lb_o | output | 1 | Left-bottom gate enable |
| gate_rt_o | output | 1 | Right-top gate enable |
| gate_rb_o | output | 1 | Right-bottom gate enable |

## Verification
The bench drives exact cycle sequences at the leg handovers. A stage that ignored D, or counted one cycle too few, would turn the new switch on too early; a stage with no gap at all would show shoot-through at D = 0. It counts alternating-mode low phases that are interleaved with bottom-short phases, so a rail flag that advanced on every low phase would pick the wrong pair. It moves `mode_i` in the middle of a low phase, where a design that sampled the mode continuously would cut the freewheel interval short. It releases `fault_i` after one cycle while the drive keeps toggling, which exposes a fault that is not latched. Random drive widths down to one cycle check that requests which change faster than the dead time never produce overlapping gates.

// File: rtl/hb_pkg.sv
package hb_pkg;

    // Freewheel behaviour applied during the drive low phase
    typedef enum logic [1:0] {
        FW_FLOAT     = 2'd0,
        FW_LOW_SHORT = 2'd1,
        FW_ALT_SHORT = 2'd2,
        FW_SPARE     = 2'd3
    } fw_mode_e;

    // Gate pair of one half-bridge leg
    typedef struct packed {
        logic top;
        logic bot;
    } leg_t;

    localparam int NUM_LEGS = 2;
    localparam int LEG_L    = 0;
    localparam int LEG_R    = 1;

endpackage

// File: rtl/hb_phase.sv
module hb_phase
    import hb_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       drive_i,
    input  logic [1:0] mode_i,
    output leg_t       req_l_o,
    output leg_t       req_r_o
);

    typedef struct packed {
        logic drv;   // drive line seen at the previous edge
        logic par;   // 0: next period is even
        logic alt;   // 0: next alternating short uses bottom rail
        leg_t l;
        leg_t r;
    } phase_t;

    phase_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.drv = drive_i;
        if (drive_i && !st_q.drv) begin
            st_d.par = ~st_q.par;
            if (!st_q.par) begin
                st_d.l = '{top: 1'b1, bot: 1'b0};
                st_d.r = '{top: 1'b0, bot: 1'b1};
            end else begin
                st_d.l = '{top: 1'b0, bot: 1'b1};
                st_d.r = '{top: 1'b1, bot: 1'b0};
            end
        end else if (!drive_i && st_q.drv) begin
            unique case (fw_mode_e'(mode_i))
                FW_LOW_SHORT: begin
                    st_d.l = '{top: 1'b0, bot: 1'b1};
                    st_d.r = '{top: 1'b0, bot: 1'b1};
                end
                FW_ALT_SHORT: begin
                    st_d.l   = '{top: st_q.alt, bot: ~st_q.alt};
                    st_d.r   = '{top: st_q.alt, bot: ~st_q.alt};
                    st_d.alt = ~st_q.alt;
                end
                default: begin
                    st_d.l = '0;
                    st_d.r = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign req_l_o = st_q.l;
    assign req_r_o = st_q.r;

endmodule

// File: rtl/hb_leg.sv
module hb_leg
    import hb_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEAD_W-1:0] dead_i,
    input  leg_t              req_i,
    output leg_t              gate_o
);

    localparam logic [DEAD_W-1:0] CNT_MAX = {DEAD_W{1'b1}};
    localparam logic [DEAD_W-1:0] CNT_ONE = DEAD_W'(1);

    typedef struct packed {
        leg_t              g;
        logic [DEAD_W-1:0] cnt;  // cycles the leg has spent fully off
    } leg_st_t;

    leg_st_t st_d, st_q;
    leg_t    want;
    logic    drop, idle;

    always_comb begin
        want = (req_i.top && req_i.bot) ? '0 : req_i;
        drop = (st_q.g.top && !want.top) || (st_q.g.bot && !want.bot);
        idle = !st_q.g.top && !st_q.g.bot;
        st_d = st_q;
        if (drop) begin
            st_d.g   = '0;
            st_d.cnt = CNT_ONE;
        end else if (idle) begin
            if ((want.top || want.bot) && (st_q.cnt >= dead_i)) begin
                st_d.g = want;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.g   <= '0;
            st_q.cnt <= CNT_MAX;
        end else begin
            st_q <= st_d;
        end
    end

    assign gate_o = st_q.g;

endmodule

// File: rtl/hbridge_seq.sv
module hbridge_seq
    import hb_pkg::*;
#(
    parameter int DEAD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              drive_i,
    input  logic [1:0]        mode_i,
    input  logic [DEAD_W-1:0] dead_i,
    input  logic              fault_i,
    output logic              gate_lt_o,
    output logic              gate_lb_o,
    output logic              gate_rt_o,
    output logic              gate_rb_o
);

    leg_t req   [NUM_LEGS];
    leg_t gates [NUM_LEGS];
    logic flt_d, flt_q;

    hb_phase u_phase (
        .clk     (clk),
        .rst     (rst),
        .drive_i (drive_i),
        .mode_i  (mode_i),
        .req_l_o (req[LEG_L]),
        .req_r_o (req[LEG_R])
    );

    for (genvar i = 0; i < NUM_LEGS; i++) begin : g_leg
        hb_leg #(.DEAD_W(DEAD_W)) u_leg (
            .clk    (clk),
            .rst    (rst),
            .dead_i (dead_i),
            .req_i  (req[i]),
            .gate_o (gates[i])
        );
    end

    always_comb begin
        flt_d = flt_q | fault_i;
    end

    always_ff @(posedge clk) begin
        if (rst) flt_q <= 1'b0;
        else     flt_q <= flt_d;
    end

    assign gate_lt_o = gates[LEG_L].top & ~flt_q;
    assign gate_lb_o = gates[LEG_L].bot & ~flt_q;
    assign gate_rt_o = gates[LEG_R].top & ~flt_q;
    assign gate_rb_o = gates[LEG_R].bot & ~flt_q;

endmodule

// File: rtl/hb_seq_chk.sv
module hb_seq_chk (
    input logic clk,
    input logic rst,
    input logic fault_i,
    input logic gate_lt_o,
    input logic gate_lb_o,
    input logic gate_rt_o,
    input logic gate_rb_o
);

    logic any_on;
    assign any_on = gate_lt_o | gate_lb_o | gate_rt_o | gate_rb_o;

    // R7
    left_no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_lt_o && gate_lb_o));

    // R7
    right_no_shoot_chk: assert property (@(posedge clk) disable iff (rst)
        !(gate_rt_o && gate_rb_o));

    // R8
    left_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_lt_o) || $rose(gate_lb_o)) |-> !$past(gate_lt_o || gate_lb_o));

    // R8
    right_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(gate_rt_o) || $rose(gate_rb_o)) |-> !$past(gate_rt_o || gate_rb_o));

    // R10
    fault_blank_chk: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> !any_on);

    // R1
    reset_off_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> !any_on);

endmodule

bind hbridge_seq hb_seq_chk u_hb_seq_chk (
    .clk       (clk),
    .rst       (rst),
    .fault_i   (fault_i),
    .gate_lt_o (gate_lt_o),
    .gate_lb_o (gate_lb_o),
    .gate_rt_o (gate_rt_o),
    .gate_rb_o (gate_rb_o)
);

// File: tb/tb_hbridge_seq.sv
module tb_hbridge_seq;

    localparam int DW      = 8;
    localparam int CNT_TOP = (1 << DW) - 1;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst = 1'b1;
    logic          drive = 1'b0;
    logic          fault = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [DW-1:0] dead = '0;
    logic          lt, lb, rt, rb;

    hbridge_seq #(.DEAD_W(DW)) dut (
        .clk(clk), .rst(rst), .drive_i(drive), .mode_i(mode), .dead_i(dead),
        .fault_i(fault), .gate_lt_o(lt), .gate_lb_o(lb), .gate_rt_o(rt), .gate_rb_o(rb)
    );

    int checks = 0;
    int errors = 0;

    // reference model, index 0 lt, 1 lb, 2 rt, 3 rb
    bit m_drv, m_par, m_alt, m_flt;
    bit m_req [4];
    bit m_g   [4];
    int m_cnt [2];
    int offrun [2];

    function automatic int max1(int v);
        return (v < 1) ? 1 : v;
    endfunction

    function automatic logic [3:0] exp_vec();
        logic [3:0] v;
        v = {m_g[0], m_g[1], m_g[2], m_g[3]};
        return m_flt ? 4'b0000 : v;
    endfunction

    function automatic logic [3:0] req_vec();
        return {m_req[0], m_req[1], m_req[2], m_req[3]};
    endfunction

    task automatic model_step();
        if (rst) begin
            m_drv = 0; m_par = 0; m_alt = 0; m_flt = 0;
            for (int i = 0; i < 4; i++) begin m_req[i] = 0; m_g[i] = 0; end
            m_cnt[0] = CNT_TOP; m_cnt[1] = CNT_TOP;
            return;
        end
        for (int li = 0; li < 2; li++) begin
            int t = 2 * li;
            int b = 2 * li + 1;
            if ((m_g[t] && !m_req[t]) || (m_g[b] && !m_req[b])) begin
                m_g[t] = 0; m_g[b] = 0; m_cnt[li] = 1;
            end else if (!m_g[t] && !m_g[b]) begin
                if ((m_req[t] || m_req[b]) && m_cnt[li] >= int'(dead)) begin
                    m_g[t] = m_req[t]; m_g[b] = m_req[b];
                end else if (m_cnt[li] < CNT_TOP) begin
                    m_cnt[li]++;
                end
            end
        end
        if (drive && !m_drv) begin
            if (!m_par) begin m_req[0] = 1; m_req[1] = 0; m_req[2] = 0; m_req[3] = 1; end
            else        begin m_req[0] = 0; m_req[1] = 1; m_req[2] = 1; m_req[3] = 0; end
            m_par = !m_par;
        end else if (!drive && m_drv) begin
            if (mode == 2'd1) begin
                m_req[0] = 0; m_req[1] = 1; m_req[2] = 0; m_req[3] = 1;
            end else if (mode == 2'd2) begin
                m_req[0] = m_alt; m_req[1] = !m_alt; m_req[2] = m_alt; m_req[3] = !m_alt;
                m_alt = !m_alt;
            end else begin
                for (int i = 0; i < 4; i++) m_req[i] = 0;
            end
        end
        m_drv = drive;
        m_flt = m_flt | fault;
    endtask

    function automatic string tag_now();
        if (m_flt) return "R10";
        if (exp_vec() != req_vec()) return "R8";
        if (m_drv) return m_par ? "R2" : "R3";
        if (req_vec() == 4'b0000) return "R4";
        if (req_vec() == 4'b1010) return "R6";
        return "R5";
    endfunction

    task automatic compare();
        logic [3:0] act;
        act = {lt, lb, rt, rb};
        checks++;
        if (act !== exp_vec()) begin
            errors++;
            $display("FAIL %s gates actual %b expected %b", tag_now(), act, exp_vec());
        end
        checks++;
        if ((lt && lb) || (rt && rb)) begin
            errors++;
            $display("FAIL R7 shoot-through actual %b expected no leg with both on", act);
        end
        for (int li = 0; li < 2; li++) begin
            logic on_now;
            on_now = (li == 0) ? (lt | lb) : (rt | rb);
            if (rst) begin
                offrun[li] = 100000;
            end else if (on_now) begin
                if (offrun[li] > 0) begin
                    checks++;
                    if (offrun[li] < max1(int'(dead))) begin
                        errors++;
                        $display("FAIL R8 leg %0d off gap actual %0d expected >= %0d",
                                 li, offrun[li], max1(int'(dead)));
                    end
                end
                offrun[li] = 0;
            end else begin
                offrun[li]++;
            end
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic expect_vec(logic [3:0] e, string tag);
        checks++;
        if ({lt, lb, rt, rb} !== e) begin
            errors++;
            $display("FAIL %s directed actual %b expected %b", tag, {lt, lb, rt, rb}, e);
        end
    endtask

    task automatic period(int hi, int lo, logic [1:0] md);
        drive = 1'b1;
        repeat (hi) cyc();
        mode  = md;
        drive = 1'b0;
        repeat (lo) cyc();
    endtask

    initial begin
        #(200000 * 10);
        checks++;
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int hold;
        offrun[0] = 100000; offrun[1] = 100000;
        void'($urandom(32'd20240613));
        @(negedge clk);
        rst = 1'b1; dead = 8'd2; mode = 2'd1;
        repeat (3) cyc();
        expect_vec(4'b0000, "R1");
        rst = 1'b0;
        repeat (2) cyc();
        expect_vec(4'b0000, "R1");

        // R2 even period and R8 latency from an idle leg
        drive = 1'b1;
        cyc(); expect_vec(4'b0000, "R8");
        cyc(); expect_vec(4'b1001, "R2");
        repeat (3) cyc();

        // R5 bottom short, R8 exact dead-time gap of 2
        drive = 1'b0;
        cyc(); expect_vec(4'b1001, "R8");
        cyc(); expect_vec(4'b0001, "R8");
        cyc(); expect_vec(4'b0001, "R8");
        cyc(); expect_vec(4'b0101, "R5");

        // R9 mode change inside low phase ignored
        mode = 2'd0;
        repeat (4) cyc();
        expect_vec(4'b0101, "R9");

        // R3 odd period
        drive = 1'b1;
        cyc(); expect_vec(4'b0101, "R8");
        cyc(); expect_vec(4'b0100, "R8");
        cyc(); expect_vec(4'b0100, "R8");
        cyc(); expect_vec(4'b0110, "R3");

        // R4 float
        drive = 1'b0;
        repeat (5) cyc();
        expect_vec(4'b0000, "R4");

        // R6 alternation advances only on alternating-mode low phases
        period(6, 6, 2'd2); expect_vec(4'b0101, "R6");
        period(6, 6, 2'd1); expect_vec(4'b0101, "R5");
        period(6, 6, 2'd2); expect_vec(4'b1010, "R6");
        period(6, 6, 2'd3); expect_vec(4'b0000, "R4");

        // R10 latched fault
        drive = 1'b1;
        repeat (6) cyc();
        fault = 1'b1;
        cyc(); expect_vec(4'b0000, "R10");
        fault = 1'b0;
        period(5, 5, 2'd1); expect_vec(4'b0000, "R10");
        period(5, 5, 2'd2); expect_vec(4'b0000, "R10");

        // random segments
        for (int seg = 0; seg < 12; seg++) begin
            rst = 1'b1; fault = 1'b0; drive = 1'b0;
            dead = DW'($urandom_range(0, 5));
            repeat (2) cyc();
            expect_vec(4'b0000, "R1");
            rst = 1'b0;
            hold = 0;
            for (int c = 0; c < 400; c++) begin
                if (hold == 0) begin
                    drive = ~drive;
                    hold = $urandom_range(1, 12);
                end
                hold--;
                if ($urandom_range(0, 9) == 0) mode = 2'($urandom_range(0, 3));
                fault = ($urandom_range(0, 599) == 0);
                cyc();
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule